// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Combiner

This block sits behind the analog chain of a nine-stage pipelined analog-to-digital converter. Eight stages each resolve one and a half bits and hand over a two-bit decision worth 0, 1 or 2. A last stage holds a single comparator and hands over one bit. Each stage sees a given sample one clock after the stage in front of it, so the nine decisions for one sample reach the block over nine consecutive clocks.

The block lines those decisions up with per-stage skew registers. The first stage gets the deepest delay line and the comparator gets none. Once aligned, the codes are added with each stage shifted one bit position below the stage before it. That overlap addition removes the redundancy and yields a 10-bit straight-binary word. A valid flag that entered with the first stage's decision travels down a matching delay line and comes out with the word. Any two-bit code of 3 is illegal and raises a sticky error flag.

Top module: `pipe_adc_corrector`

## Requirements
- R1: The decision of stage k (k = 1..8) is carried on `stage_codes[2k-1:2k-2]`, with stage 1 in the two least significant bits. For a given sample, stage k's decision arrives k-1 clocks after stage 1's, and `final_bit` arrives 8 clocks after stage 1's.
- R2: For a valid sample with codes c1..c8 and comparator bit f, `out_code` equals c1·256 + c2·128 + c3·64 + c4·32 + c5·16 + c6·8 + c7·4 + c8·2 + f.
- R3: When every stage decides 1 and the comparator decides 1, the output is the mid-scale code 511.
- R4: When every stage decides 0 and the comparator decides 0, the output is 0. When every stage decides 2 and the comparator decides 1, the output is 1021, the top of the legal range.
- R5: When `in_valid` is high in the cycle where stage 1's decision is presented, `out_valid` and the matching `out_code` can be seen 9 clock edges later.
- R6: `out_valid` repeats the `in_valid` pattern, gaps included, 9 clocks later. While `out_valid` is low, `out_code` holds the last valid word.
- R7: If the weighted sum exceeds 1023, which can only happen when a code of 3 is present, `out_code` saturates at 1023.
- R8: A code of 3 on any two-bit stage input sets `code_err` at the next clock edge, whatever the state of `in_valid`. Legal codes never set it.
- R9: `code_err` stays high once set, until reset.
- R10: A synchronous active-high `rst` clears every alignment register, `out_valid`, `out_code` and `code_err`. Samples that were in flight before the reset never show up as valid afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a real sample; goes with stage 1's decision |
| stage_codes | input | 16 | Current two-bit decisions of the eight 1.5-bit stages |
| final_bit | input | 1 | Decision of the last comparator stage |
| out_valid | output | 1 | Output word is valid |
| out_code | output | 10 | Corrected straight-binary sample |
| code_err | output | 1 | Sticky flag for an illegal stage code |

## Verification
A sample whose stage-1 decision is driven before clock edge n appears on `out_code` and `out_valid` just after edge n+8, nine edges in total. The error flag follows an illegal code after one edge. The bench drives stimulus on falling edges and feeds each stage of a sample one clock later than the stage before it. At each falling edge it first compares the outputs against the sample whose stage-1 decision went in nine falling edges earlier, and only then drives the next inputs. Sticky-flag, hold and reset checks are sampled at the first falling edge after the edge that should produce them, and they stay sampled over the following idle cycles.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  typedef logic [1:0] stage_code_t;
  localparam stage_code_t CODE_ILLEGAL = 2'd3;
  localparam stage_code_t CODE_MID     = 2'd1;
endpackage

// File: rtl/skew_line.sv
module skew_line #(
  parameter int W     = 2,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) taps[j] <= '0;
    end else begin
      taps[0] <= d;
      for (int j = 1; j < DEPTH; j++) taps[j] <= taps[j-1];
    end
  end

  assign q = taps[DEPTH-1];
endmodule

// File: rtl/overlap_sum.sv
module overlap_sum
  import adc_corr_pkg::*;
#(
  parameter int NSTG = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [2*NSTG-1:0]   codes,
  input  logic                lsb,
  output logic                q_valid,
  output logic [NSTG+1:0]     q_code
);
  localparam int OUT_W = NSTG + 2;
  localparam int SUM_W = OUT_W + 1;
  localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << OUT_W) - 1);
  localparam logic [OUT_W-1:0] MIDV = OUT_W'((1 << (OUT_W - 1)) - 1);

  logic [SUM_W-1:0] acc;
  logic [OUT_W-1:0] sat;
  logic             all_mid;

  always_comb begin
    acc = SUM_W'(lsb);
    for (int i = 0; i < NSTG; i++) begin
      acc = acc + (SUM_W'(codes[2*i +: 2]) << (NSTG - i));
    end
    sat = (acc > MAXV) ? MAXV[OUT_W-1:0] : acc[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_code  <= '0;
    end else begin
      q_valid <= en;
      if (en) q_code <= sat;
    end
  end

  assign all_mid = (codes == {NSTG{CODE_MID}}) && lsb;

  AST_SATURATE_TOP: assert property (@(posedge clk) disable iff (rst)
    (en && (acc > MAXV)) |=> (q_code == '1)); // R7
  AST_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
    (en && all_mid) |=> (q_code == MIDV)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(rst)) |=> $stable(q_code)); // R6
endmodule

// File: rtl/code_monitor.sv
module code_monitor
  import adc_corr_pkg::*;
#(
  parameter int NSTG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*NSTG-1:0] codes,
  output logic              err
);
  logic bad;

  always_comb begin
    bad = 1'b0;
    for (int i = 0; i < NSTG; i++) begin
      if (codes[2*i +: 2] == CODE_ILLEGAL) bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      err <= 1'b0;
    else if (bad) err <= 1'b1;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    bad |=> err); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R9
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
  import adc_corr_pkg::*;
#(
  parameter int NSTG = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2*NSTG-1:0]   stage_codes,
  input  logic                final_bit,
  output logic                out_valid,
  output logic [NSTG+1:0]     out_code,
  output logic                code_err
);
  logic [2*NSTG-1:0] codes_al;
  logic              valid_al;

  // stage i+1 is i clocks late, so it needs NSTG-i registers to line up
  for (genvar i = 0; i < NSTG; i++) begin : g_skew
    skew_line #(.W(2), .DEPTH(NSTG - i)) u_skew (
      .clk (clk),
      .rst (rst),
      .d   (stage_codes[2*i +: 2]),
      .q   (codes_al[2*i +: 2])
    );
  end

  skew_line #(.W(1), .DEPTH(NSTG)) u_vskew (
    .clk (clk),
    .rst (rst),
    .d   (in_valid),
    .q   (valid_al)
  );

  overlap_sum #(.NSTG(NSTG)) u_sum (
    .clk     (clk),
    .rst     (rst),
    .en      (valid_al),
    .codes   (codes_al),
    .lsb     (final_bit),
    .q_valid (out_valid),
    .q_code  (out_code)
  );

  code_monitor #(.NSTG(NSTG)) u_mon (
    .clk   (clk),
    .rst   (rst),
    .codes (stage_codes),
    .err   (code_err)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && !code_err && (out_code == '0))); // R10
endmodule

// File: tb/pipe_adc_corrector_tb.sv
`timescale 1ns/1ps
module pipe_adc_corrector_tb_top;
  localparam int NSTG = 8;
  localparam int LAT  = NSTG + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [2*NSTG-1:0] stage_codes = '0;
  logic              final_bit = 1'b0;
  logic              out_valid;
  logic [NSTG+1:0]   out_code;
  logic              code_err;

  int checks = 0;
  int errors = 0;
  int last_code = 0;
  int sc [40][NSTG];
  bit sf [40];
  bit sv [40];

  always #2 clk = ~clk;

  pipe_adc_corrector #(.NSTG(NSTG)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .stage_codes(stage_codes),
    .final_bit(final_bit), .out_valid(out_valid), .out_code(out_code),
    .code_err(code_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int s);
    int acc = int'(sf[s]);
    for (int k = 0; k < NSTG; k++) acc += sc[s][k] << (NSTG - k);
    if (acc > 1023) acc = 1023;
    return acc;
  endfunction

  task automatic drive_idle();
    in_valid = 1'b0; stage_codes = '0; final_bit = 1'b0;
  endtask

  // R1: stage k of sample s is presented in cycle s+k-1, comparator in s+8
  task automatic run_stream(input int n, input string tag);
    for (int c = 0; c < n + LAT + 1; c++) begin
      @(negedge clk);
      if (c >= LAT && c - LAT < n) begin
        int s = c - LAT;
        chk({tag, " R5/R6 out_valid"}, int'(out_valid), int'(sv[s]));
        if (sv[s]) begin
          chk({tag, " R2 out_code"}, int'(out_code), model(s));
          last_code = model(s);
        end else begin
          chk({tag, " R6 hold"}, int'(out_code), last_code);
        end
      end
      for (int k = 0; k < NSTG; k++) begin
        int idx = c - k;
        stage_codes[2*k +: 2] = (idx >= 0 && idx < n) ? 2'(sc[idx][k]) : 2'd0;
      end
      final_bit = (c - NSTG >= 0 && c - NSTG < n) ? sf[c - NSTG] : 1'b0;
      in_valid  = (c < n) ? sv[c] : 1'b0;
    end
    drive_idle();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; drive_idle();
    @(negedge clk);
    @(negedge clk);
    chk("R10 reset out_valid", int'(out_valid), 0);
    chk("R10 reset out_code", int'(out_code), 0);
    chk("R10 reset code_err", int'(code_err), 0);
    rst = 1'b0;
    last_code = 0;
  endtask

  task automatic t_basic();
    for (int s = 0; s < 12; s++) begin
      sv[s] = 1'b1;
      for (int k = 0; k < NSTG; k++) sc[s][k] = (s + k) % 3;
      sf[s] = bit'(s % 2);
    end
    for (int k = 0; k < NSTG; k++) begin sc[0][k] = 1; sc[1][k] = 0; sc[2][k] = 2; end
    sf[0] = 1; sf[1] = 0; sf[2] = 1;
    chk("R3 model mid", model(0), 511);
    chk("R4 model zero", model(1), 0);
    chk("R4 model top", model(2), 1021);
    run_stream(12, "basic");
    chk("R8 no flag on legal codes", int'(code_err), 0);
  endtask

  task automatic t_gaps();
    for (int s = 0; s < 15; s++) begin
      sv[s] = (s % 3) != 1;
      for (int k = 0; k < NSTG; k++) sc[s][k] = (s * 7 + k * 5) % 3;
      sf[s] = bit'((s / 2) % 2);
    end
    run_stream(15, "gaps");
  endtask

  task automatic t_latency();
    for (int s = 0; s < 8; s++) begin
      sv[s] = (s == 3);
      for (int k = 0; k < NSTG; k++) sc[s][k] = (k == 0) ? 2 : 0;
      sf[s] = 1'b1;
    end
    run_stream(8, "latency R5");
  endtask

  task automatic t_saturate();
    for (int s = 0; s < 4; s++) begin
      sv[s] = 1'b1; sf[s] = 1'b1;
      for (int k = 0; k < NSTG; k++) sc[s][k] = 2;
    end
    sc[0][0] = 3;
    sc[1][1] = 3;
    sc[2][0] = 1;
    chk("R7 model sat", model(0), 1023);
    run_stream(4, "saturate R7");
    chk("R8 flag after illegal code", int'(code_err), 1);
  endtask

  task automatic t_sticky();
    for (int s = 0; s < 5; s++) begin
      sv[s] = 1'b1; sf[s] = 1'b0;
      for (int k = 0; k < NSTG; k++) sc[s][k] = 1;
    end
    run_stream(5, "sticky");
    chk("R9 flag sticky", int'(code_err), 1);
    do_reset();
    chk("R9 flag cleared by reset", int'(code_err), 0);
  endtask

  task automatic t_err_invalid();
    @(negedge clk);
    in_valid = 1'b0;
    stage_codes = '0;
    stage_codes[9:8] = 2'd3;
    @(negedge clk);
    drive_idle();
    chk("R8 flag with in_valid low", int'(code_err), 1);
    do_reset();
  endtask

  task automatic t_midreset();
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_valid = 1'b1; stage_codes = {NSTG{2'b01}}; final_bit = 1'b1;
    end
    @(negedge clk);
    rst = 1'b1; drive_idle();
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk("R10 no stale valid", int'(out_valid), 0);
    end
    last_code = 0;
    for (int s = 0; s < 3; s++) begin
      sv[s] = 1'b1; sf[s] = 1'b1;
      for (int k = 0; k < NSTG; k++) sc[s][k] = 1;
    end
    run_stream(3, "refill R10");
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_basic();
    t_gaps();
    t_latency();
    t_saturate();
    t_sticky();
    t_err_invalid();
    t_midreset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule